// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous static memory. A command is taken on each rising clock edge. The command carries a synchronous chip select, a global write strobe, one write strobe per byte lane, and an address. A read puts its word into an output register one edge after the command edge. A write uses late-write timing: its data is sampled one edge after the command. The data then waits one more cycle in a write buffer before it reaches the array.

The write buffer can hold a write that the array does not yet contain. For this reason a read forwards each enabled lane of a pending write to the output. Reads and writes can therefore be mixed in any order with no idle cycles between them. The shared data bus is modelled as separate input and output vectors. The output drivers are represented by an enable flag that follows the output-enable pin combinationally. Depth, lane count and lane width are parameters.

Top module: `lwsram`

## Requirements
- R1: While reset is high at a clock edge, the output register is cleared to zero and any buffered write is discarded.
- R2: A selected cycle with the global strobe and every lane strobe high is a read. The addressed word appears on `dout` after the second rising edge counting from the command edge.
- R3: The data for a write is sampled from `din` at the rising edge that follows the write's command edge. The value on `din` at the command edge itself is ignored.
- R4: A lane strobe `bw_n[i]` low writes lane i only. Lane i covers bits `i*LANE_W +: LANE_W`, so with 9-bit lanes lane 0 is bits 8:0 and lane 1 is bits 17:9. Lanes whose strobe is high keep their contents.
- R5: With `gw_n` low in a selected cycle, the cycle is a write of every lane, whatever the value of `bw_n`.
- R6: With `cs_n` high at an edge, the cycle neither reads nor writes, even when write strobes are low. `dout` keeps its value.
- R7: A write cycle leaves `dout` unchanged.
- R8: A read issued right after a write forwards the written lanes. This also applies when the read targets the same address. The lanes the write did not touch come from the array.
- R9: Operations run back to back with no dead cycles. Consecutive writes to one address leave the most recent value of each lane.
- R10: `dout_oe` is the inverse of `oe_n` at all times, with no dependence on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Synchronous select, active low |
| gw_n | input | 1 | Global write strobe, active low, all lanes |
| bw_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, one cycle after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Output register contents |
| dout_oe | output | 1 | Output drivers active (low means high impedance) |

## Verification
The bench builds the block with 4 address bits, which gives 16 words, and two 9-bit lanes. With only 16 words, random traffic often repeats an address within one or two cycles. That makes read-after-write forwarding and repeated writes to one word frequent events rather than rare ones. Two lanes give a lane boundary at bit 9, so byte-masked writes can show that the lane a write did not enable keeps its old value. The global strobe and the per-lane strobes also stay distinguishable.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2
    } cmd_e;

endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              gw_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_mask
);

    logic             any_wr;
    logic [LANES-1:0] lane_sel;

    always_comb begin
        lane_sel = gw_n ? ~bw_n : {LANES{1'b1}};
        any_wr   = |lane_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd      <= CMD_NOP;
            cmd_addr <= '0;
            cmd_mask <= '0;
        end else begin
            cmd_addr <= addr;
            cmd_mask <= cs_n ? '0 : lane_sel;
            if (cs_n)        cmd <= CMD_NOP;
            else if (any_wr) cmd <= CMD_WR;
            else             cmd <= CMD_RD;
        end
    end

    a_r5_global_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !gw_n) |=> (cmd == CMD_WR && &cmd_mask));

    a_r6_deselect_nop: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd == CMD_NOP));

    a_r2_read_decode: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && gw_n && &bw_n) |=> (cmd == CMD_RD));

endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] take_addr,
    input  logic [LANES-1:0]  take_mask,
    input  logic [W-1:0]      take_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LANES-1:0]  wb_mask,
    output logic [W-1:0]      wb_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_addr  <= '0;
            wb_mask  <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= take;
            if (take) begin
                wb_addr <= take_addr;
                wb_mask <= take_mask;
                wb_data <= take_data;
            end
        end
    end

    a_r3_buffer_loaded: assert property (@(posedge clk) disable iff (rst)
        take |=> (wb_valid && wb_data == $past(take_data)));

    a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_mask != '0));

endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wmask,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[l])
                store[waddr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/lwsram.sv
module lwsram
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              gw_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      din,
    input  logic              oe_n,
    output logic [W-1:0]      dout,
    output logic              dout_oe
);

    cmd_e              cmd;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_mask;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [LANES-1:0]  wb_mask;
    logic [W-1:0]      wb_data;
    logic [W-1:0]      arr_q;
    logic [W-1:0]      rd_word;
    logic [W-1:0]      out_q;

    lwsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .gw_n(gw_n), .bw_n(bw_n),
        .addr(addr), .cmd(cmd), .cmd_addr(cmd_addr), .cmd_mask(cmd_mask)
    );

    lwsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst(rst), .take(cmd == CMD_WR), .take_addr(cmd_addr),
        .take_mask(cmd_mask), .take_data(din), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_mask(wb_mask), .wb_data(wb_data)
    );

    lwsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .we(wb_valid), .waddr(wb_addr), .wmask(wb_mask),
        .wdata(wb_data), .raddr(cmd_addr), .rdata(arr_q)
    );

    // Per-lane forwarding from the write still waiting in the buffer
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        logic hit;
        assign hit = wb_valid && (wb_addr == cmd_addr) && wb_mask[l];
        assign rd_word[l*LANE_W +: LANE_W] = hit ? wb_data[l*LANE_W +: LANE_W]
                                                 : arr_q[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst)                out_q <= '0;
        else if (cmd == CMD_RD) out_q <= rd_word;
    end

    assign dout    = out_q;
    assign dout_oe = ~oe_n;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dout == '0 && !wb_valid));

    a_r7_hold_when_not_read: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_RD) |=> $stable(dout));

    a_r8_forward_lane0: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD && wb_valid && wb_addr == cmd_addr && wb_mask[0])
        |=> (dout[LANE_W-1:0] == $past(wb_data[LANE_W-1:0])));

endmodule

// File: tb/lwsram_test.sv
module lwsram_test;

    localparam int AW = 4;
    localparam int LN = 2;
    localparam int LW = 9;
    localparam int W  = LN * LW;
    localparam int DP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          gw_n = 1'b1;
    logic [LN-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic          oe_n = 1'b0;
    logic [W-1:0]  dout;
    logic          dout_oe;

    always #2 clk = ~clk;   // 250 MHz

    lwsram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .gw_n(gw_n), .bw_n(bw_n),
        .addr(addr), .din(din), .oe_n(oe_n), .dout(dout), .dout_oe(dout_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [W-1:0] ref_mem [DP];
    logic [W-1:0] exp_q = '0;
    bit           prv_rd = 0;
    logic [W-1:0] prv_val = '0;
    string        prv_tag = "R1";
    bit           pend_wr = 0;
    logic [W-1:0] pend_data = '0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                          input logic [LN-1:0] m);
        logic [W-1:0] r = old;
        for (int l = 0; l < LN; l++)
            if (m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
        return r;
    endfunction

    // kind: 0 deselect, 1 read, 2 write
    task automatic op(input int kind, input logic [AW-1:0] a, input logic g,
                      input logic [LN-1:0] b, input logic [W-1:0] d, input string tag);
        logic [LN-1:0] m;
        @(negedge clk);
        check(prv_tag, dout, exp_q);
        if (prv_rd) exp_q = prv_val;
        din  = pend_wr ? pend_data : W'($urandom);
        cs_n = (kind == 0);
        addr = a;
        gw_n = (kind == 1) ? 1'b1 : g;
        bw_n = (kind == 1) ? '1 : b;
        pend_wr = 0;
        prv_rd  = 0;
        if (kind == 1) begin
            prv_rd  = 1;
            prv_val = ref_mem[a];
            prv_tag = tag;
        end else if (kind == 2) begin
            m = g ? ~b : '1;
            ref_mem[a] = merge(ref_mem[a], d, m);
            pend_wr   = 1;
            pend_data = d;
            prv_tag   = "R7";
        end else begin
            prv_tag = "R6";
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", dout, '0);       // R1 reset state

        // R10 output enable follows oe_n without a clock edge
        oe_n = 1'b1; #1 check("R10", {{(W-1){1'b0}}, dout_oe}, '0);
        oe_n = 1'b0; #1 check("R10", {{(W-1){1'b0}}, dout_oe}, 1);

        // R5 fill every word with global writes, lane strobes left high
        for (int i = 0; i < DP; i++) op(2, AW'(i), 1'b0, '1, W'($urandom), "R5");
        for (int i = 0; i < DP; i++) op(1, AW'(i), 1'b1, '1, '0, "R5");

        // R3 late-write data: bus value at command edge differs from data
        op(2, 4'd2, 1'b0, '1, 18'h2aaaa, "R3");
        op(0, 4'd0, 1'b1, '1, '0, "R3");
        op(1, 4'd2, 1'b1, '1, '0, "R3");

        // R4 lane 0 only, then lane 1 only
        op(2, 4'd3, 1'b1, 2'b10, 18'h3ffff, "R4");
        op(0, 4'd0, 1'b1, '1, '0, "R4");
        op(1, 4'd3, 1'b1, '1, '0, "R4");
        op(2, 4'd4, 1'b1, 2'b01, 18'h00000, "R4");
        op(0, 4'd0, 1'b1, '1, '0, "R4");
        op(1, 4'd4, 1'b1, '1, '0, "R4");

        // R5 global strobe overrides a high lane strobe
        op(2, 4'd5, 1'b0, 2'b11, 18'h1c3a5, "R5");
        op(0, 4'd0, 1'b1, '1, '0, "R5");
        op(1, 4'd5, 1'b1, '1, '0, "R5");

        // R8 read immediately after a partial write to the same word
        op(2, 4'd6, 1'b1, 2'b01, 18'h15555, "R8");
        op(1, 4'd6, 1'b1, '1, '0, "R8");
        op(2, 4'd7, 1'b0, '1, 18'h0f0f0, "R8");
        op(1, 4'd7, 1'b1, '1, '0, "R8");

        // R9 consecutive writes to one word, lanes overlapping, then read
        op(2, 4'd8, 1'b0, '1, 18'h11111, "R9");
        op(2, 4'd8, 1'b1, 2'b10, 18'h22222, "R9");
        op(2, 4'd8, 1'b1, 2'b01, 18'h33333, "R9");
        op(1, 4'd8, 1'b1, '1, '0, "R9");
        op(1, 4'd7, 1'b1, '1, '0, "R9");

        // R6 deselected cycle with strobes low writes nothing, dout holds
        op(0, 4'd9, 1'b0, 2'b00, '0, "R6");
        op(1, 4'd9, 1'b1, '1, '0, "R6");

        // R2 R9 random mixed traffic
        for (int i = 0; i < 600; i++) begin
            int k = $urandom % 3;
            logic [LN-1:0] b = LN'($urandom);
            logic g = 1'(($urandom % 4) != 0);
            if (k == 2 && g && b == '1) b = 2'b10;
            op(k, AW'($urandom), g, b, W'($urandom), "R2");
        end

        repeat (3) op(0, '0, 1'b1, '1, '0, "R6");
        v = dout;
        check("R6", dout, v);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule